// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block places accepted Ethernet frames into a circular receive area held in a local byte-addressed memory. The area is cut into 256-byte pages and is described by four page pointers: the first page of the ring, the page one past its end, the page the next frame will occupy (the write page) and the page the host has not yet released (the release page). Frames arrive as a byte stream marked with valid, start and end flags. Each payload byte is written through a single memory write port as soon as it is accepted. Frames shorter than the minimum are padded with zeros.

Once the payload is stored, the block writes a four-byte header in front of it. The header carries a status byte, the page where the following frame will start, and the stored length. The block then advances the write page and raises a receive-done flag. A free-space check against the release page refuses frames that might not fit, and refuses all frames while the receiver is halted. A frame that starts while an earlier one is still being written is dropped and reported with a one-cycle pulse.

Top module: `rx_ring_writer`

## Requirements
- R1: Pointers and mask are loaded by `cfg_we` with `cfg_sel` codes 0 = ring first page, 1 = ring end page, 2 = release page, 3 = write page, 4 = interrupt mask (bit 0), 5 = flag clear (write 1 in bit 0). After reset all pointers are 0, the flag and the mask are 0, and `irq` is low.
- R2: Byte addresses are a page number times 256. Free space is (release − write) if the write page is below the release page, else (end − first) − (write − release). `buf_full` is high when free space is below 1518 bytes, including at reset.
- R3: A frame whose start byte arrives while `buf_full` or `rx_halt` is high is refused entirely: no memory write, and the write page is unchanged.
- R4: A frame of fewer than 60 bytes is stored as 60 bytes, with zero bytes after its last real byte.
- R5: The payload is written from address write page × 256 + 4 upward. When the address reaches end page × 256, it continues at first page × 256.
- R6: The header is written at write page × 256 + 0..3 as: status, next page, stored length + 4 low byte, then the high byte. Status is 0x01, or 0x21 when bit 0 of the first frame byte is set.
- R7: Next page = write page + (stored length + 4 + 4 + 255) / 256 (integer division). If the result is at or past the end page, (end − first) is subtracted.
- R8: After the fourth header byte the write page takes the next-page value and `rx_flag` is set. `irq` is high exactly when `rx_flag` and mask bit 0 are both high.
- R9: A start byte that arrives while a frame is still in progress (payload, padding or header) raises `drop_pulse` for one cycle. That frame is not stored, and the frame in progress completes normally.
- R10: Each memory write appears on the port one clock after the byte that caused it was accepted; the first payload byte of a frame arrives one clock after its start byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register load strobe |
| cfg_sel | input | 3 | Register select code (R1) |
| cfg_data | input | PAGE_W | Load value |
| rx_halt | input | 1 | Receiver halted; refuse new frames |
| in_valid | input | 1 | Frame byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | PAGE_W+8 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| cur_page | output | PAGE_W | Current write page |
| buf_full | output | 1 | Free space below one maximal frame |
| rx_flag | output | 1 | Receive-done status |
| irq | output | 1 | Masked interrupt |
| drop_pulse | output | 1 | Frame dropped because the block was busy |

## Verification
A wrong write pointer or wrap decision shows up at the memory port as a stray address during the payload of the same frame. A wrong length count or next-page computation shows up in the header bytes, which appear four clocks after the padding ends. A wrong free-space result shows directly on `buf_full` in the cycle after a pointer load, and as a missing or extra frame write. A stuck state machine shows up one frame later, as a missing header, an unmoved `cur_page` or a spurious `drop_pulse`.

// File: rtl/rxr_pkg.sv
// Shared types and constants for the receive ring writer.
package rxr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_PAD  = 2'd2,
        ST_HDR  = 2'd3
    } rxr_state_e;

    localparam logic [2:0] SEL_FIRST = 3'd0;
    localparam logic [2:0] SEL_END   = 3'd1;
    localparam logic [2:0] SEL_REL   = 3'd2;
    localparam logic [2:0] SEL_CUR   = 3'd3;
    localparam logic [2:0] SEL_MASK  = 3'd4;
    localparam logic [2:0] SEL_CLR   = 3'd5;

    localparam logic [7:0] STAT_GOOD  = 8'h01;
    localparam logic [7:0] STAT_GROUP = 8'h20;
endpackage

// File: rtl/rxr_space.sv
// Free-space judge: compares the room between the write page and the
// release page with one maximal frame. Assumes pointers lie in the ring.
module rxr_space #(
    parameter int PAGE_W = 8,
    parameter int ROOM   = 1518
) (
    input  logic [PAGE_W-1:0] first_pg,
    input  logic [PAGE_W-1:0] end_pg,
    input  logic [PAGE_W-1:0] cur_pg,
    input  logic [PAGE_W-1:0] rel_pg,
    output logic              full
);
    localparam int SW = PAGE_W + 10;

    logic signed [SW-1:0] s_first, s_end, s_cur, s_rel, avail_pg, avail_b;

    // Signed page arithmetic so a misconfigured ring reads as full.
    always_comb begin
        s_first = $signed({{(SW-PAGE_W){1'b0}}, first_pg});
        s_end   = $signed({{(SW-PAGE_W){1'b0}}, end_pg});
        s_cur   = $signed({{(SW-PAGE_W){1'b0}}, cur_pg});
        s_rel   = $signed({{(SW-PAGE_W){1'b0}}, rel_pg});
        if (cur_pg < rel_pg)
            avail_pg = s_rel - s_cur;
        else
            avail_pg = (s_end - s_first) - (s_cur - s_rel);
        avail_b = avail_pg <<< 8;
        full    = avail_b < $signed(SW'(ROOM));
    end
endmodule

// File: rtl/rxr_link.sv
// Next-page calculator: pages taken by header, data and trailer slack,
// folded back into the ring. Assumes first_pg < end_pg.
module rxr_link #(
    parameter int PAGE_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic [PAGE_W-1:0] cur_pg,
    input  logic [PAGE_W-1:0] first_pg,
    input  logic [PAGE_W-1:0] end_pg,
    input  logic [LEN_W-1:0]  total,
    output logic [PAGE_W-1:0] next_pg
);
    localparam int SUM_W = (LEN_W > PAGE_W ? LEN_W : PAGE_W) + 2;

    logic [SUM_W-1:0] span, sum;

    // Round total plus slack up to whole pages, then wrap once.
    always_comb begin
        span = (SUM_W'(total) + SUM_W'(259)) >> 8;
        sum  = SUM_W'(cur_pg) + span;
        if (sum >= SUM_W'(end_pg))
            sum = sum - (SUM_W'(end_pg) - SUM_W'(first_pg));
        next_pg = sum[PAGE_W-1:0];
    end
endmodule

// File: rtl/rx_ring_writer.sv
// Receive ring writer: accepts a framed byte stream, stores payload into a
// paged circular memory area, pads short frames, writes a 4-byte header
// and advances the write page. Assumes the pointers are not reloaded
// while a frame is in progress and first page < end page.
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int PAGE_W  = 8,
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 60,
    parameter int ROOM    = 1518
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_sel,
    input  logic [PAGE_W-1:0]   cfg_data,
    input  logic                rx_halt,
    input  logic                in_valid,
    input  logic                in_sof,
    input  logic                in_eof,
    input  logic [7:0]          in_data,
    output logic                mem_we,
    output logic [PAGE_W+7:0]   mem_addr,
    output logic [7:0]          mem_wdata,
    output logic [PAGE_W-1:0]   cur_page,
    output logic                buf_full,
    output logic                rx_flag,
    output logic                irq,
    output logic                drop_pulse
);
    localparam int ADDR_W = PAGE_W + 8;

    rxr_state_e         state;
    logic [PAGE_W-1:0]  first_pg, end_pg, rel_pg;
    logic               mask;
    logic [ADDR_W-1:0]  wptr, first_addr, end_addr, cur_addr, data0_addr;
    logic [ADDR_W-1:0]  wptr_step, data0_step;
    logic [LEN_W-1:0]   len, len_inc, total;
    logic               grp;
    logic [1:0]         hcnt;
    logic [PAGE_W-1:0]  next_pg;
    logic [7:0]         hdr_byte;
    logic               cur_load;

    rxr_space #(.PAGE_W(PAGE_W), .ROOM(ROOM)) u_space (
        .first_pg(first_pg), .end_pg(end_pg), .cur_pg(cur_page),
        .rel_pg(rel_pg), .full(buf_full)
    );

    rxr_link #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_link (
        .cur_pg(cur_page), .first_pg(first_pg), .end_pg(end_pg),
        .total(total), .next_pg(next_pg)
    );

    // Byte addresses, wrapped pointer steps and the header byte mux.
    always_comb begin
        first_addr = {first_pg, 8'h00};
        end_addr   = {end_pg, 8'h00};
        cur_addr   = {cur_page, 8'h00};
        data0_addr = cur_addr + ADDR_W'(4);
        wptr_step  = (wptr + 1'b1 == end_addr) ? first_addr : wptr + 1'b1;
        data0_step = (data0_addr + 1'b1 == end_addr) ? first_addr : data0_addr + 1'b1;
        len_inc    = len + 1'b1;
        total      = len + LEN_W'(4);
        cur_load   = cfg_we && (cfg_sel == SEL_CUR);
        case (hcnt)
            2'd0:    hdr_byte = STAT_GOOD | (grp ? STAT_GROUP : 8'h00);
            2'd1:    hdr_byte = 8'(next_pg);
            2'd2:    hdr_byte = total[7:0];
            default: hdr_byte = total[15:8];
        endcase
        irq = rx_flag && mask;
    end

    // Frame sequencing, memory port, pointers and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;  wptr <= '0;  len <= '0;  grp <= 1'b0;
            hcnt <= 2'd0;  mem_we <= 1'b0;  mem_addr <= '0;  mem_wdata <= '0;
            first_pg <= '0;  end_pg <= '0;  rel_pg <= '0;  cur_page <= '0;
            mask <= 1'b0;  rx_flag <= 1'b0;  drop_pulse <= 1'b0;
        end else begin
            mem_we     <= 1'b0;
            drop_pulse <= 1'b0;
            if (cfg_we) begin
                case (cfg_sel)
                    SEL_FIRST: first_pg <= cfg_data;
                    SEL_END:   end_pg   <= cfg_data;
                    SEL_REL:   rel_pg   <= cfg_data;
                    SEL_MASK:  mask     <= cfg_data[0];
                    SEL_CLR:   if (cfg_data[0]) rx_flag <= 1'b0;
                    default: ;
                endcase
            end
            if (state != ST_IDLE && in_valid && in_sof)
                drop_pulse <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (in_valid && in_sof && !buf_full && !rx_halt) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= data0_addr;
                        mem_wdata <= in_data;
                        wptr      <= data0_step;
                        len       <= LEN_W'(1);
                        grp       <= in_data[0];
                        hcnt      <= 2'd0;
                        if (in_eof)
                            state <= (1 < MIN_LEN) ? ST_PAD : ST_HDR;
                        else
                            state <= ST_RECV;
                    end
                end
                ST_RECV: begin
                    if (in_valid && !in_sof) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= wptr;
                        mem_wdata <= in_data;
                        wptr      <= wptr_step;
                        len       <= len_inc;
                        if (in_eof)
                            state <= (len_inc < LEN_W'(MIN_LEN)) ? ST_PAD : ST_HDR;
                    end
                end
                ST_PAD: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= wptr;
                    mem_wdata <= 8'h00;
                    wptr      <= wptr_step;
                    len       <= len_inc;
                    if (len_inc >= LEN_W'(MIN_LEN))
                        state <= ST_HDR;
                end
                default: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= cur_addr + ADDR_W'(hcnt);
                    mem_wdata <= hdr_byte;
                    hcnt      <= hcnt + 1'b1;
                    if (hcnt == 2'd3) begin
                        cur_page <= next_pg;
                        rx_flag  <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
            endcase
            if (cur_load)
                cur_page <= cfg_data;
        end
    end

    // R3: refused frames cause no write and keep the sequencer idle.
    p_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && in_valid && in_sof && (buf_full || rx_halt))
        |=> (state == ST_IDLE && !mem_we));

    // R4: every padding cycle produces a zero byte write.
    p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD) |=> (mem_we && mem_wdata == 8'h00));

    // R5: writes never leave the ring.
    p_in_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr >= first_addr && mem_addr < end_addr));

    // R8: the last header byte sets the flag and moves the write page.
    p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HDR && hcnt == 2'd3 && !cur_load)
        |=> (rx_flag && cur_page == $past(next_pg)));

    // R8: the write page only moves on frame completion or a load.
    p_cur_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_HDR && !cur_load) |=> $stable(cur_page));

    // R9: a start byte during a frame in progress is reported.
    p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && in_valid && in_sof) |=> drop_pulse);
endmodule

// File: tb/rx_ring_writer_test.sv
module rx_ring_writer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [7:0]  cfg_data = '0;
    logic        rx_halt = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = '0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  cur_page;
    logic        buf_full, rx_flag, irq, drop_pulse;

    int tests = 0, fails = 0, wcount = 0, dcount = 0;
    bit done = 0;
    logic [7:0] bmem [int];

    always #10 clk = ~clk;

    rx_ring_writer uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .rx_halt(rx_halt), .in_valid(in_valid),
        .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cur_page(cur_page), .buf_full(buf_full), .rx_flag(rx_flag),
        .irq(irq), .drop_pulse(drop_pulse)
    );

    // Memory model and event counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (mem_we) begin
            bmem[int'(mem_addr)] = mem_wdata;
            wcount++;
        end
        if (drop_pulse) dcount++;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(logic [2:0] sel, logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    function automatic logic [7:0] pat(int i, logic [7:0] first, int seed);
        return (i == 0) ? first : 8'(i * 7 + seed);
    endfunction

    task automatic send(int len, logic [7:0] first, int seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1);
            in_data = pat(i, first, seed);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ring(logic [7:0] fp, logic [7:0] ep, logic [7:0] cp, logic [7:0] rp);
        cfg(3'd0, fp); cfg(3'd1, ep); cfg(3'd2, rp); cfg(3'd3, cp);
        cfg(3'd5, 8'h01);
    endtask

    // {first, end, cur, release, len[15:0], first byte, next page, status}
    localparam int NV = 7;
    localparam logic [71:0] VEC [NV] = '{
        {8'h40, 8'h80, 8'h40, 8'h40, 16'd100, 8'h02, 8'h41, 8'h01},
        {8'h40, 8'h80, 8'h45, 8'h40, 16'd30,  8'h01, 8'h46, 8'h21},
        {8'h40, 8'h80, 8'h7F, 8'h60, 16'd300, 8'h00, 8'h41, 8'h01},
        {8'h40, 8'h80, 8'h50, 8'h40, 16'd252, 8'hFF, 8'h52, 8'h21},
        {8'h40, 8'h80, 8'h60, 8'h40, 16'd60,  8'h04, 8'h61, 8'h01},
        {8'h40, 8'h80, 8'h61, 8'h40, 16'd1,   8'h03, 8'h62, 8'h21},
        {8'h40, 8'h80, 8'h7E, 8'h70, 16'd252, 8'h00, 8'h40, 8'h01}
    };

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 / R2 reset state
        check("R1 reset cur_page", cur_page, 0);
        check("R1 reset rx_flag", rx_flag, 0);
        check("R1 reset irq", irq, 0);
        check("R2 reset buf_full", buf_full, 1);

        // Table-driven frames: R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            logic [7:0] fp, ep, cp, rp, fb, nx, st;
            int len, plen, a, bad, w0;
            logic [15:0] tot;
            {fp, ep, cp, rp} = VEC[v][71:40];
            len = int'(VEC[v][39:24]);
            {fb, nx, st} = VEC[v][23:0];
            ring(fp, ep, cp, rp);
            bmem.delete();
            w0 = wcount;
            check("R8 flag cleared by code 5", rx_flag, 0);
            send(len, fb, v);
            idle(80);
            plen = (len < 60) ? 60 : len;
            tot = 16'(plen + 4);
            a = int'(cp) * 256;
            check("R6 header status", bmem.exists(a) ? bmem[a] : 8'hxx, st);
            check("R7 header next page", bmem.exists(a+1) ? bmem[a+1] : 8'hxx, nx);
            check("R6 header length low", bmem.exists(a+2) ? bmem[a+2] : 8'hxx, tot[7:0]);
            check("R6 header length high", bmem.exists(a+3) ? bmem[a+3] : 8'hxx, tot[15:8]);
            a = a + 4;
            bad = -1;
            for (int i = 0; i < plen; i++) begin
                logic [7:0] e;
                e = (i < len) ? pat(i, fb, v) : 8'h00;
                if (!bmem.exists(a) || bmem[a] !== e) begin
                    if (bad < 0) bad = i;
                end
                a = a + 1;
                if (a == int'(ep) * 256) a = int'(fp) * 256;
            end
            check((len < 60) ? "R4 padded payload" : "R5 payload with wrap", bad, -1);
            check("R4 write count", wcount - w0, plen + 4);
            check("R8 cur_page advanced", cur_page, nx);
            check("R8 rx_flag set", rx_flag, 1);
        end

        // R8 interrupt masking
        check("R8 irq masked off", irq, 0);
        cfg(3'd4, 8'h01);
        check("R8 irq with mask", irq, 1);
        cfg(3'd5, 8'h01);
        check("R8 irq after clear", irq, 0);
        cfg(3'd4, 8'h00);

        // R2 / R3 free-space refusal
        begin
            int w0;
            ring(8'h40, 8'h80, 8'h40, 8'h45);
            check("R2 full at 1280 bytes", buf_full, 1);
            w0 = wcount;
            send(80, 8'h00, 9);
            idle(80);
            check("R3 full refuse writes", wcount - w0, 0);
            check("R3 full refuse cur_page", cur_page, 8'h40);
            cfg(3'd2, 8'h46);
            check("R2 not full at 1536 bytes", buf_full, 0);
            rx_halt = 1'b1;
            w0 = wcount;
            send(80, 8'h00, 9);
            idle(80);
            check("R3 halt refuse writes", wcount - w0, 0);
            check("R3 halt refuse cur_page", cur_page, 8'h40);
            rx_halt = 1'b0;
        end

        // R9 busy drop
        begin
            int w0, d0;
            ring(8'h40, 8'h80, 8'h50, 8'h40);
            w0 = wcount; d0 = dcount;
            send(60, 8'h00, 3);
            send(10, 8'h00, 4);
            idle(80);
            check("R9 drop pulse count", dcount - d0, 1);
            check("R9 only first frame stored", cur_page, 8'h51);
            check("R9 write count", wcount - w0, 64);
        end

        // R10 write latency
        ring(8'h40, 8'h80, 8'h60, 8'h40);
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b0; in_data = 8'hA5;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        check("R10 write one clock later", mem_we, 1);
        check("R10 first data address", mem_addr, 16'h6004);
        check("R10 first data byte", mem_wdata, 8'hA5);
        @(negedge clk);
        in_valid = 1'b1; in_eof = 1'b1; in_data = 8'h11;
        @(negedge clk);
        in_valid = 1'b0; in_eof = 1'b0;
        idle(80);
        check("R10 frame completes", cur_page, 8'h61);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule